// File: doc/BRIEF.md
# Odd-Parity and Four-Ones Serial Recognizer

This block reads a serial bit stream one bit per clock and raises a flag when the bits accepted since reset meet two conditions. The total number of 1s must be odd. The stream must also have contained, at some point, an unbroken run of `RUN_LEN` ones, where `RUN_LEN` defaults to four. Only bits offered with the valid strobe are counted.

The recognizer is the product of two small machines. A two-state tracker follows parity. A run detector counts consecutive ones. Once it reaches `RUN_LEN` it locks in its final state and stays there until reset. With the default length this gives 2 x 5 = 10 product states.

The run detector can be built in two encodings, chosen by a parameter: a saturating binary counter or a thermometer shift chain. The output is registered. It changes on the same clock edge that accepts the bit that decides it. Detection starts again only after a synchronous reset.

Top module: `srec_top`

## Requirements
- R1: While `rst` is high at a clock edge, the design clears its state to even parity and a zero run count. `match` is 0 after that edge.
- R2: An accepted 1 flips the parity condition. An accepted 0 leaves it unchanged.
- R3: The run condition becomes true only on the accepted 1 that completes `RUN_LEN` (default 4) consecutive accepted ones. An accepted 0 before that point restarts the run count at zero.
- R4: Once the run condition is true, it stays true for every later input, 0 or 1, until reset.
- R5: `match` is 1 exactly when the parity of the accepted ones is odd and the run condition is true.
- R6: A cycle with `in_valid` low changes no state. `in_bit` is ignored on that cycle and `match` keeps its value.
- R7: `match` is registered. It takes the value that accounts for a bit at the same clock edge that accepts that bit, so it is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_bit` carries a bit to accept |
| in_bit | input | 1 | Serial data bit |
| match | output | 1 | Registered flag: odd count of ones and a run of `RUN_LEN` ones seen |

## Verification
The parity flip and the completion of the run can happen on the same accepted 1. In that cycle `match` may rise from both causes at once, or it may stay low when the completing 1 makes the parity even. The sweep over every 10-bit stream from reset produces every placement of that coincidence, including a run that completes on the first four bits and a run whose completing bit is also the fifth or an odd-numbered one. After each bit, the bench compares `match` with a model that keeps only a parity bit, a run count and a sticky flag. A random stream with gaps in `in_valid` tests the same coincidence falling between held cycles.

// File: rtl/srec_pkg.sv
package srec_pkg;
   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_t;

   localparam int RUN_STYLE_COUNT = 0;
   localparam int RUN_STYLE_THERM = 1;
endpackage

// File: rtl/srec_parity_trk.sv
module srec_parity_trk
   import srec_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic bit_i,
   output logic odd_o,
   output logic odd_nxt_o
);
   par_t par_q, par_d;

   always_comb begin
      par_d = par_q;
      if (adv && bit_i)
         par_d = (par_q == PAR_EVEN) ? PAR_ODD : PAR_EVEN;
   end

   always_ff @(posedge clk) begin
      if (rst) par_q <= PAR_EVEN;
      else     par_q <= par_d;
   end

   assign odd_o     = (par_q == PAR_ODD);
   assign odd_nxt_o = (par_d == PAR_ODD);

   AST_PAR_FLIP: assert property (@(posedge clk) disable iff (rst)
      (adv && bit_i) |=> (odd_o != $past(odd_o)));                 // R2
   AST_PAR_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
      (adv && !bit_i) |=> $stable(odd_o));                         // R2
   AST_PAR_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(odd_o));                                    // R6
endmodule

// File: rtl/srec_run_det.sv
module srec_run_det
   import srec_pkg::*;
#(
   parameter int RUN_LEN   = 4,
   parameter int RUN_STYLE = RUN_STYLE_COUNT
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic bit_i,
   output logic done_o,
   output logic done_nxt_o
);
   localparam int CW = $clog2(RUN_LEN + 1);

   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("srec_run_det: RUN_LEN must be at least 2");
      end
      if (RUN_STYLE != RUN_STYLE_COUNT && RUN_STYLE != RUN_STYLE_THERM) begin : g_bad_style
         $error("srec_run_det: unknown RUN_STYLE");
      end

      if (RUN_STYLE == RUN_STYLE_THERM) begin : g_therm
         logic [RUN_LEN-1:0] th_q, th_d;
         always_comb begin
            th_d = th_q;
            if (adv && !th_q[RUN_LEN-1]) begin
               if (bit_i) th_d = {th_q[RUN_LEN-2:0], 1'b1};
               else       th_d = '0;
            end
         end
         always_ff @(posedge clk) begin
            if (rst) th_q <= '0;
            else     th_q <= th_d;
         end
         assign done_o     = th_q[RUN_LEN-1];
         assign done_nxt_o = th_d[RUN_LEN-1];
      end else begin : g_count
         localparam logic [CW-1:0] TOP = CW'(RUN_LEN);
         logic [CW-1:0] cnt_q, cnt_d;
         always_comb begin
            cnt_d = cnt_q;
            if (adv && cnt_q != TOP) begin
               if (bit_i) cnt_d = cnt_q + CW'(1);
               else       cnt_d = '0;
            end
         end
         always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
         end
         assign done_o     = (cnt_q == TOP);
         assign done_nxt_o = (cnt_d == TOP);

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= TOP);                                         // R3
      end
   endgenerate

   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
      done_o |=> done_o);                                          // R4
   AST_RUN_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> $past(adv && bit_i));                      // R3
   AST_RUN_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(done_o));                                   // R6
endmodule

// File: rtl/srec_top.sv
module srec_top
   import srec_pkg::*;
#(
   parameter int RUN_LEN   = 4,
   parameter int RUN_STYLE = RUN_STYLE_COUNT
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_bit,
   output logic match
);
   logic odd_q, odd_d, run_q, run_d, match_q;

   srec_parity_trk u_par (
      .clk       (clk),
      .rst       (rst),
      .adv       (in_valid),
      .bit_i     (in_bit),
      .odd_o     (odd_q),
      .odd_nxt_o (odd_d)
   );

   srec_run_det #(.RUN_LEN(RUN_LEN), .RUN_STYLE(RUN_STYLE)) u_run (
      .clk        (clk),
      .rst        (rst),
      .adv        (in_valid),
      .bit_i      (in_bit),
      .done_o     (run_q),
      .done_nxt_o (run_d)
   );

   always_ff @(posedge clk) begin
      if (rst) match_q <= 1'b0;
      else     match_q <= odd_d & run_d;
   end

   assign match = match_q;

   AST_RST_CLEAR: assert property (@(posedge clk)
      rst |=> !match);                                             // R1
   AST_MATCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
      match |-> run_q);                                            // R5
   AST_MATCH_NEEDS_ODD: assert property (@(posedge clk) disable iff (rst)
      match |-> odd_q);                                            // R5
   AST_MATCH_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(match));                               // R6
endmodule

// File: tb/tb_srec_top.sv
module tb_srec_top;
   localparam int RUN = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic match;

   int errors = 0;
   int checks = 0;

   bit m_odd;
   int m_cnt;
   bit m_seen;

   srec_top #(.RUN_LEN(RUN)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .match(match)
   );

   always #4 clk = ~clk;

   initial begin
      #(8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic chk(input string tag, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: match actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_odd = 0; m_cnt = 0; m_seen = 0;
   endtask

   task automatic model_take(input bit b);
      if (b) begin
         m_odd = !m_odd;
         if (!m_seen) begin
            m_cnt++;
            if (m_cnt == RUN) m_seen = 1;
         end
      end else if (!m_seen) begin
         m_cnt = 0;
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic step(input bit v, input bit b, input string tag);
      bit seen_before;
      seen_before = m_seen;
      in_valid = v; in_bit = b;
      @(posedge clk);
      if (v) model_take(b);
      @(negedge clk);
      if (tag.len() != 0)  chk(tag, match, m_odd && m_seen);
      else if (!v)         chk("R6", match, m_odd && m_seen);
      else if (seen_before) chk("R4", match, m_odd && m_seen);
      else                 chk("R3", match, m_odd && m_seen);
   endtask

   task automatic do_reset();
      rst = 1; in_valid = 1; in_bit = 1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 0; in_valid = 0;
      model_clear();
      chk("R1", match, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      do_reset();

      // R7 / R5: run completes and parity is odd on the fifth one
      step(1, 1, "R5"); step(1, 1, "R5"); step(1, 1, "R5"); step(1, 1, "R5");
      chk("R5", match, 1'b0);
      step(1, 1, "R7");
      chk("R7", match, 1'b1);
      // R2: zero keeps parity, one flips it
      step(1, 0, "R2");
      chk("R2", match, 1'b1);
      step(1, 1, "R2");
      chk("R2", match, 1'b0);
      step(1, 1, "R2");
      // R6: held cycles with in_bit high change nothing
      for (int i = 0; i < 6; i++) step(0, 1, "R6");
      chk("R6", match, 1'b1);

      // R3: a zero at count RUN-1 restarts the run
      do_reset();
      step(1, 1, ""); step(1, 1, ""); step(1, 1, ""); step(1, 0, "R3");
      step(1, 1, ""); step(1, 1, ""); step(1, 1, "R3");
      chk("R3", match, 1'b0);
      step(1, 1, "R3");
      chk("R3", match, 1'b1);
      // R4: long zero stretch leaves the run seen
      for (int i = 0; i < 20; i++) step(1, 0, "R4");
      step(1, 1, "R4");
      chk("R4", match, 1'b0);
      step(1, 1, "R4");
      chk("R4", match, 1'b1);

      // exhaustive sweep over all 10-bit streams from reset
      for (int p = 0; p < 1024; p++) begin
         do_reset();
         for (int k = 0; k < 10; k++) step(1, p[k], "");
      end

      // random stream with valid gaps
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         if (i % 700 == 699) do_reset();
         step(($urandom % 4) != 0, ($urandom % 3) != 0, "");
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule